// File: doc/BRIEF.md
# Iterative Radix-16 Signed Multiply-Accumulate Unit

This block multiplies two 16-bit two's-complement operands by retiring one 4-bit multiplier digit per clock cycle. Each cycle the multiplicand, sign-extended onto a 24-bit datapath, is multiplied by the current digit. The partial product is added into a running sum that then moves right by four bits. A full 16x16 product therefore takes exactly four cycles. The three low digits are treated as unsigned values 0..15. The top digit is treated as a signed value -8..7, so the sign of the multiplier is handled without a correction step.

A one-cycle `start` pulse captures both operands and the accumulate selection. `busy` is high during the four step cycles. `done` is a one-cycle pulse that marks a new value on `product`.
- With accumulate mode off, `product` takes the new product.
- With accumulate mode on, the new product is added to the value already held, modulo 2^32.

Operand width and digit width are parameters. The datapath width is the operand width plus two digits.

Top module: `radix16_mac`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` pulse while idle raises `busy` for exactly four cycles, one per digit. `done` rises in the cycle after the fourth step, at the same edge where `busy` falls.
- R3: With `acc_mode` low, `product` equals the exact signed 32-bit product of `mcand` and `mplr` for every sign combination. Both operands are read as two's complement.
- R4: -32768 times -32768 yields 0x40000000 (+1073741824). The internal running sum never needs more bits than its datapath provides.
- R5: A `start` pulse while `busy` is high is ignored. The operation in progress keeps its operands, its mode and its latency.
- R6: `done` is high for exactly one cycle per operation.
- R7: When `acc_mode` is high at `start`, the completed `product` equals the previous `product` plus the new signed product, truncated to 32 bits.
- R8: `product` changes only at the edge that raises `done`. It holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only when idle) |
| acc_mode | input | 1 | 1: add result to held product; 0: replace it |
| mcand | input | 16 | Signed multiplicand |
| mplr | input | 16 | Signed multiplier |
| busy | output | 1 | Step cycles in progress |
| done | output | 1 | One-cycle pulse: new product available |
| product | output | 32 | Signed product or accumulated sum |

## Verification
The bench builds two copies of the block. The default build (16-bit operands, 4-bit digits) is used for the exact corner products, the accumulate chain that wraps past 2^32, latency, pulse width, and the start pulses that must be ignored while busy. A second build with 8-bit operands and 4-bit digits takes only two steps per operation. This makes it affordable to sweep every multiplicand against every third multiplier from -128 to 127. That sweep exercises the signed top digit and the unsigned low digit against arithmetic done in the bench.

// File: rtl/mac16_pkg.sv
// Package: shared types for the iterative radix-16 multiplier.
// Assumes nothing beyond IEEE 1800-2017.
package mac16_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mac_state_e;
endpackage

// File: rtl/mac_digit_pick.sv
// Selects multiplier digit number idx and extends it to the datapath width.
// Assumes OPW is a multiple of DIGW. Lower digits are unsigned; the top
// digit is signed so the multiplier's sign is absorbed without correction.
module mac_digit_pick #(
    parameter int OPW  = 16,
    parameter int DIGW = 4,
    parameter int MCW  = OPW + 2*DIGW,
    parameter int IDXW = 2
) (
    input  logic [OPW-1:0]  mplr,
    input  logic [IDXW-1:0] idx,
    output logic [MCW-1:0]  digit_ext
);
    localparam int STEPS = OPW / DIGW;

    logic [DIGW-1:0] raw;
    logic            is_top;

    // Slice the digit and extend it by sign only for the top digit.
    always_comb begin
        raw       = mplr[int'(idx)*DIGW +: DIGW];
        is_top    = (idx == IDXW'(STEPS-1));
        digit_ext = {{(MCW-DIGW){is_top & raw[DIGW-1]}}, raw};
    end
endmodule

// File: rtl/mac_pp_gen.sv
// Forms one partial product: sign-extended multiplicand times one digit.
// Assumes digit_ext is already extended; the result fits MCW bits.
module mac_pp_gen #(
    parameter int OPW = 16,
    parameter int MCW = 24
) (
    input  logic [OPW-1:0] mcand,
    input  logic [MCW-1:0] digit_ext,
    output logic [MCW-1:0] pp
);
    logic signed [MCW-1:0] mc_ext;
    logic signed [MCW-1:0] dg_s;

    // Multiply on the full datapath width; the truncation loses nothing.
    always_comb begin
        mc_ext = $signed({{(MCW-OPW){mcand[OPW-1]}}, mcand});
        dg_s   = $signed(digit_ext);
        pp     = mc_ext * dg_s;
    end
endmodule

// File: rtl/mac_acc_stage.sv
// Running-sum register pair: a signed upper part and a shift-in lower part.
// Each step adds a partial product to the upper part and shifts the pair
// right by one digit. Assumes clear and step are never high together.
module mac_acc_stage #(
    parameter int OPW  = 16,
    parameter int DIGW = 4,
    parameter int MCW  = OPW + 2*DIGW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [MCW-1:0]    pp,
    output logic [2*OPW-1:0]  prod_next
);
    logic signed [MCW-1:0] hi_q;
    logic        [OPW-1:0] lo_q;
    logic signed [MCW-1:0] sum;
    logic signed [MCW-1:0] hi_d;
    logic        [OPW-1:0] lo_d;

    // Add the partial product, then shift one digit out into the low part.
    always_comb begin
        sum       = hi_q + $signed(pp);
        hi_d      = sum >>> DIGW;
        lo_d      = {sum[DIGW-1:0], lo_q[OPW-1:DIGW]};
        prod_next = {hi_d[OPW-1:0], lo_d};
    end

    // Hold the running sum; cleared at the start of each operation.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (step) begin
            hi_q <= hi_d;
            lo_q <= lo_d;
        end
    end

    // R4: the sum never leaves its OPW+DIGW+1 significant bits.
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (sum[MCW-1:OPW+DIGW] == '0 || sum[MCW-1:OPW+DIGW] == '1));
endmodule

// File: rtl/radix16_mac.sv
// Iterative signed multiplier retiring one DIGW-bit digit per cycle.
// Assumes OPW is a multiple of DIGW and OPW/DIGW >= 2. A start pulse while
// busy is ignored; acc_mode is sampled together with the operands.
module radix16_mac
    import mac16_pkg::*;
#(
    parameter int OPW  = 16,
    parameter int DIGW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             acc_mode,
    input  logic [OPW-1:0]   mcand,
    input  logic [OPW-1:0]   mplr,
    output logic             busy,
    output logic             done,
    output logic [2*OPW-1:0] product
);
    localparam int STEPS = OPW / DIGW;
    localparam int MCW   = OPW + 2*DIGW;
    localparam int IDXW  = (STEPS > 2) ? $clog2(STEPS) : 1;

    mac_state_e         state_q;
    logic [IDXW-1:0]    idx_q;
    logic [OPW-1:0]     a_q;
    logic [OPW-1:0]     b_q;
    logic               mode_q;
    logic               done_q;
    logic [2*OPW-1:0]   result_q;
    logic [MCW-1:0]     digit_ext;
    logic [MCW-1:0]     pp;
    logic [2*OPW-1:0]   prod_next;
    logic               accept;
    logic               last_step;

    // Decode handshake conditions from the controller state.
    always_comb begin
        busy      = (state_q == ST_RUN);
        accept    = (state_q == ST_IDLE) && start;
        last_step = busy && (idx_q == IDXW'(STEPS-1));
        done      = done_q;
        product   = result_q;
    end

    mac_digit_pick #(.OPW(OPW), .DIGW(DIGW), .MCW(MCW), .IDXW(IDXW)) u_digit (
        .mplr      (b_q),
        .idx       (idx_q),
        .digit_ext (digit_ext)
    );

    mac_pp_gen #(.OPW(OPW), .MCW(MCW)) u_pp (
        .mcand     (a_q),
        .digit_ext (digit_ext),
        .pp        (pp)
    );

    mac_acc_stage #(.OPW(OPW), .DIGW(DIGW), .MCW(MCW)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .step      (busy),
        .pp        (pp),
        .prod_next (prod_next)
    );

    // Sequence the steps, latch operands and write the result on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            a_q      <= '0;
            b_q      <= '0;
            mode_q   <= 1'b0;
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                state_q <= ST_RUN;
                idx_q   <= '0;
                a_q     <= mcand;
                b_q     <= mplr;
                mode_q  <= acc_mode;
            end else if (busy) begin
                idx_q <= idx_q + 1'b1;
                if (last_step) begin
                    state_q  <= ST_IDLE;
                    done_q   <= 1'b1;
                    result_q <= mode_q ? (result_q + prod_next) : prod_next;
                end
            end
        end
    end

    // R6: done lasts one cycle.
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2: busy ends exactly where done begins.
    assert_busy_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R5: a busy unit stays busy until its last step, whatever start does.
    assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last_step) |=> (busy && $stable(a_q) && $stable(b_q) && $stable(mode_q)));
    // R8: product only moves with done.
    assert_product_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(product));
endmodule

// File: tb/radix16_mac_bench.sv
module radix16_mac_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic        start, acc_mode;
    logic [15:0] mcand, mplr;
    logic        busy, done;
    logic [31:0] product;

    logic        n_start;
    logic [7:0]  n_mcand, n_mplr;
    logic        n_busy, n_done;
    logic [15:0] n_product;

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 1'b0;
    logic [31:0] model;

    radix16_mac #(.OPW(16), .DIGW(4)) u_radix16_mac (
        .clk(clk), .rst_n(rst_n), .start(start), .acc_mode(acc_mode),
        .mcand(mcand), .mplr(mplr), .busy(busy), .done(done), .product(product));

    radix16_mac #(.OPW(8), .DIGW(4)) u_radix16_mac_small (
        .clk(clk), .rst_n(rst_n), .start(n_start), .acc_mode(1'b0),
        .mcand(n_mcand), .mplr(n_mplr), .busy(n_busy), .done(n_done), .product(n_product));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Runs one operation on the 16-bit unit; noise pulses start while busy.
    task automatic run16(input logic signed [15:0] a, input logic signed [15:0] b,
                         input bit mode, input bit noise);
        int lat;
        logic [31:0] held;
        logic signed [31:0] full;
        full = 32'(a) * 32'(b);
        model = mode ? model + full : full;
        @(negedge clk);
        start = 1'b1; mcand = a; mplr = b; acc_mode = mode;
        @(negedge clk);
        start = noise; mcand = ~a; mplr = b + 16'd1; acc_mode = ~mode;
        lat = 1;
        check(busy == 1'b1, "R2", longint'(busy), 1);
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
            if (!done) check(busy == 1'b1, "R2", longint'(busy), 1);
        end
        start = 1'b0;
        check(lat == 5, noise ? "R5" : "R2", lat, 5);
        check(busy == 1'b0, "R2", longint'(busy), 0);
        check(product == model, noise ? "R5" : (mode ? "R7" : "R3"),
              longint'(product), longint'(model));
        held = product;
        @(negedge clk);
        check(done == 1'b0, "R6", longint'(done), 0);
        @(negedge clk);
        check(product == held, "R8", longint'(product), longint'(held));
    endtask

    // Runs one operation on the 8-bit unit (two steps).
    task automatic run8(input logic signed [7:0] a, input logic signed [7:0] b);
        int lat;
        logic [15:0] exp;
        exp = 16'(16'(a) * 16'(b));
        @(negedge clk);
        n_start = 1'b1; n_mcand = a; n_mplr = b;
        @(negedge clk);
        n_start = 1'b0;
        lat = 1;
        while (!n_done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        if (lat != 3) check(1'b0, "R2", lat, 3);
        check(n_product == exp, "R3", longint'(n_product), longint'(exp));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] lcg;
        rst_n = 1'b0; start = 1'b0; acc_mode = 1'b0; mcand = '0; mplr = '0;
        n_start = 1'b0; n_mcand = '0; n_mplr = '0;
        model = '0;
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && product == 0, "R1", longint'(product), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && done == 0 && product == 0, "R1", longint'(product), 0);

        // R4 corner, then other sign mixes for R3.
        run16(-16'sd32768, -16'sd32768, 1'b0, 1'b0);
        check(product == 32'h4000_0000, "R4", longint'(product), 64'h4000_0000);
        run16(16'sd32767, 16'sd32767, 1'b0, 1'b0);
        run16(-16'sd32768, 16'sd32767, 1'b0, 1'b0);
        run16(16'sd32767, -16'sd32768, 1'b0, 1'b0);
        run16(-16'sd1, -16'sd1, 1'b0, 1'b0);
        run16(16'sd0, -16'sd123, 1'b0, 1'b0);
        run16(16'sd12345, -16'sd6789, 1'b0, 1'b0);
        run16(-16'sd30000, -16'sd2, 1'b0, 1'b0);
        run16(16'sd1, -16'sd32768, 1'b0, 1'b0);

        // R5: start held high throughout busy with different operands.
        run16(16'sd4660, -16'sd22136, 1'b0, 1'b1);
        run16(-16'sd7, 16'sd9, 1'b1, 1'b1);

        // R7: accumulate chain that wraps past 2^32.
        run16(16'sd100, 16'sd200, 1'b0, 1'b0);
        for (int k = 0; k < 6; k++) run16(16'sd32767, 16'sd32767, 1'b1, 1'b0);
        run16(-16'sd32768, 16'sd3, 1'b1, 1'b0);

        // R3: pseudo-random pairs on the default build.
        lcg = 32'h1234_5678;
        for (int k = 0; k < 200; k++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            run16(lcg[31:16], lcg[15:0], 1'b0, 1'b0);
        end

        // R3: all multiplicands against every third multiplier, 8-bit build.
        for (int a = -128; a < 128; a++)
            for (int b = -128; b < 128; b += 3)
                run8(8'(a), 8'(b));

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule